// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

A register-programmed drawing engine that fills or copies axis-aligned rectangles held in a linear pixel buffer. Software loads a raster operation, a fill colour, a pixel format (depth code and line pitch) and the corner points of a source and a destination rectangle. A write to the control register then launches the operation. The engine visits every pixel of the destination rectangle through a single synchronous memory port (read data returns one cycle after the request). Busy is visible in the status word until the last pixel has been written.

Copies between overlapping rectangles come out correct because the walk order is chosen from the relative placement of the two rectangles. When the source lies below the destination, or on the same row and to its right, the walk runs forward from the top-left corner. In every other case it runs backward from the bottom-right corner.

The controller is a four-state machine:
- ST_IDLE: waits for a command.
- ST_RD_SRC: reads the source pixel.
- ST_RD_DST: reads the destination pixel and keeps the source value.
- ST_WRITE: writes the result and steps to the next pixel.

The transitions are:
- launch: ST_IDLE to the entry state of the operation.
- src_to_dst: ST_RD_SRC to ST_RD_DST, for an XOR copy.
- src_to_write: ST_RD_SRC to ST_WRITE, for a plain copy.
- dst_to_write: ST_RD_DST to ST_WRITE.
- next_pixel: ST_WRITE back to the entry state.
- finish: ST_WRITE to ST_IDLE after the last pixel.

The entry state depends on the operation:
- ST_RD_SRC for any copy.
- ST_RD_DST for an XOR fill.
- ST_WRITE for a plain fill.

Top module: `rect_engine`

## Requirements
- R1: The register window has eight word registers. They are: 0 control/status, 1 raster operation (bits 7:0), 2 fill colour, 3 format (pitch in bits PITCH_W-1:0 in units of 8 pixels, depth code in bits 18:16), 4 source start, 5 source end, 6 destination start, 7 destination end. Reading registers 1 to 7 returns the last value written.
- R2: Each point register holds the row in bits 31:16 and the column in bits 15:0. The end point is inclusive, so a w-by-h rectangle at (x,y) ends at (x+w-1, y+h-1). Exactly the pixels inside that rectangle are written.
- R3: Depth code 0 gives 1 byte per pixel. Codes 1 and 5 give 2 bytes per pixel, of which only bits 15:0 are written. Code 2 gives 4 bytes per pixel. Any other code acts as code 0. The byte address of a pixel is (row*pitch*8 + column) * bytes per pixel, and written data is cut to the pixel width.
- R4: A fill (control bit 0 = 0) with raster operation 0xCC writes the fill colour to every pixel.
- R5: Raster operation 0x66 writes the value XORed with the current destination pixel. Every code other than 0x66 behaves as 0xCC.
- R6: A copy (control bit 0 = 1) with 0xCC writes each source pixel to the destination pixel at the same offset within the rectangle.
- R7: A copy runs forward (row by row from top-left, columns ascending) when the source row is greater than the destination row, or the rows are equal and the source column is greater. Otherwise it runs backward from the bottom-right corner. Overlapping copies therefore behave as if the source were read before it was overwritten.
- R8: A copy with 0x66 writes source XOR destination.
- R9: Bits 31:28 of the status word read as all ones from the cycle after a control write until the operation ends. A control write during that time is ignored. An operation takes 1 cycle per pixel for a plain fill, 2 for an XOR fill or plain copy, and 3 for an XOR copy.
- R10: The done output is high for exactly one cycle, the cycle after the last pixel write. In that same cycle busy reads zero.
- R11: Writes to registers 4 to 7 while busy leave them unchanged.
- R12: After reset, status reads zero, done and mem_req are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Pixel memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Pixel byte address |
| mem_wdata | output | 32 | Pixel write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong walk direction or a corrupted row/column counter does not show up as a bad address in the same cycle. It shows up in the buffer contents once the operation ends, because an overlapping copy then picks up pixels it has already overwritten. The bench therefore compares the whole buffer after every operation against a model computed in walk order. A state machine that skips or repeats a read state changes the number of busy cycles, which is checked exactly against pixels times cycles per pixel. A stuck or doubled done pulse is visible one cycle after the last write.

// File: rtl/rect_pkg.sv
package rect_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE
    } rect_state_e;

    typedef struct packed {
        logic [15:0] y;
        logic [15:0] x;
    } rect_pt_t;

    localparam logic [7:0] ROP_PASS = 8'hCC;
    localparam logic [7:0] ROP_XOR  = 8'h66;

    localparam logic [2:0] RIX_CTRL   = 3'd0;
    localparam logic [2:0] RIX_ROP    = 3'd1;
    localparam logic [2:0] RIX_COLOUR = 3'd2;
    localparam logic [2:0] RIX_FMT    = 3'd3;
    localparam logic [2:0] RIX_SRC_S  = 3'd4;
    localparam logic [2:0] RIX_SRC_E  = 3'd5;
    localparam logic [2:0] RIX_DST_S  = 3'd6;
    localparam logic [2:0] RIX_DST_E  = 3'd7;

    // log2 of bytes per pixel for a depth code
    function automatic logic [1:0] depth_shift(input logic [2:0] code);
        case (code)
            3'd2:       return 2'd2;
            3'd1, 3'd5: return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic [31:0] pixel_mask(input logic [1:0] shift);
        case (shift)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/rect_regs.sv
module rect_regs
    import rect_pkg::*;
#(
    parameter int PITCH_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [2:0]         addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    input  logic               busy_i,
    output logic               start_o,
    output logic               cmd_copy_o,
    output logic [7:0]         rop_o,
    output logic [31:0]        colour_o,
    output logic [PITCH_W-1:0] pitch_o,
    output logic [2:0]         depth_o,
    output rect_pt_t           src_s_o,
    output rect_pt_t           src_e_o,
    output rect_pt_t           dst_s_o,
    output rect_pt_t           dst_e_o
);

    localparam int NREG = 8;

    logic [31:0] word_w [NREG];

    assign word_w[0] = {{4{busy_i}}, 28'd0};

    for (genvar i = 1; i < NREG; i++) begin : g_word
        logic [31:0] q;
        logic        wr_en;
        if (i >= int'(RIX_SRC_S)) begin : g_pt
            assign wr_en = we_i && (addr_i == 3'(i)) && !busy_i;
        end else begin : g_cfg
            assign wr_en = we_i && (addr_i == 3'(i));
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en)
                q <= wdata_i;
        end
        assign word_w[i] = q;
    end

    assign rdata_o    = word_w[addr_i];
    assign start_o    = we_i && (addr_i == RIX_CTRL) && !busy_i;
    assign cmd_copy_o = wdata_i[0];
    assign rop_o      = word_w[RIX_ROP][7:0];
    assign colour_o   = word_w[RIX_COLOUR];
    assign pitch_o    = word_w[RIX_FMT][PITCH_W-1:0];
    assign depth_o    = word_w[RIX_FMT][18:16];
    assign src_s_o    = word_w[RIX_SRC_S];
    assign src_e_o    = word_w[RIX_SRC_E];
    assign dst_s_o    = word_w[RIX_DST_S];
    assign dst_e_o    = word_w[RIX_DST_E];

    AST_POINTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && we_i && addr_i >= RIX_SRC_S) |=>
            ($stable(src_s_o) && $stable(src_e_o) && $stable(dst_s_o) && $stable(dst_e_o))); // R11

endmodule

// File: rtl/rect_addr.sv
module rect_addr
    import rect_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PITCH_W = 10
) (
    input  rect_pt_t           pt_i,
    input  logic [PITCH_W-1:0] pitch_i,
    input  logic [1:0]         shift_i,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int PROD_W = 16 + PITCH_W + 3 + 1 + 2;

    logic [PROD_W-1:0] lin;
    logic [PROD_W-1:0] byte_a;

    assign lin    = PROD_W'(pt_i.y) * (PROD_W'(pitch_i) << 3) + PROD_W'(pt_i.x);
    assign byte_a = lin << shift_i;

    if (ADDR_W <= PROD_W) begin : g_trunc
        assign addr_o = byte_a[ADDR_W-1:0];
    end else begin : g_ext
        assign addr_o = ADDR_W'(byte_a);
    end

endmodule

// File: rtl/rect_rop.sv
module rect_rop (
    input  logic        xor_i,
    input  logic [31:0] src_i,
    input  logic [31:0] dst_i,
    input  logic [1:0]  shift_i,
    output logic [31:0] data_o
);
    import rect_pkg::*;

    logic [31:0] raw;

    assign raw    = xor_i ? (src_i ^ dst_i) : src_i;
    assign data_o = raw & pixel_mask(shift_i);

endmodule

// File: rtl/rect_engine.sv
module rect_engine
    import rect_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PITCH_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              done
);

    rect_state_e state_q, state_d, entry_q, entry_now;

    logic               busy, start, cmd_copy;
    logic [7:0]         rop;
    logic [31:0]        colour;
    logic [PITCH_W-1:0] pitch, pitch_q;
    logic [2:0]         depth;
    rect_pt_t           src_s, src_e, dst_s, dst_e, addr_pt;

    logic               copy_q, xor_q, desc_q, done_q, desc_now, last_px;
    logic [1:0]         shift_q;
    logic [31:0]        colour_q, src_q, src_val;
    logic [15:0]        dx, dy, sx, sy, xstep, row_first_x, row_last_x, src_first_x, last_y;

    rect_regs #(.PITCH_W(PITCH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy),
        .start_o(start), .cmd_copy_o(cmd_copy), .rop_o(rop), .colour_o(colour),
        .pitch_o(pitch), .depth_o(depth), .src_s_o(src_s), .src_e_o(src_e),
        .dst_s_o(dst_s), .dst_e_o(dst_e)
    );

    // Walk order and per-pixel entry state decided at launch
    assign desc_now  = cmd_copy && !((src_s.y > dst_s.y) ||
                                     ((src_s.y == dst_s.y) && (src_s.x > dst_s.x)));
    assign entry_now = cmd_copy ? ST_RD_SRC : ((rop == ROP_XOR) ? ST_RD_DST : ST_WRITE);

    assign row_first_x = desc_q ? dst_e.x : dst_s.x;
    assign row_last_x  = desc_q ? dst_s.x : dst_e.x;
    assign src_first_x = desc_q ? src_e.x : src_s.x;
    assign last_y      = desc_q ? dst_s.y : dst_e.y;
    assign xstep       = desc_q ? 16'hFFFF : 16'h0001;
    assign last_px     = (dx == row_last_x) && (dy == last_y);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = entry_now;
            ST_RD_SRC: state_d = xor_q ? ST_RD_DST : ST_WRITE;
            ST_RD_DST: state_d = ST_WRITE;
            ST_WRITE:  state_d = last_px ? ST_IDLE : entry_q;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q  <= ST_IDLE;
            copy_q   <= 1'b0;
            xor_q    <= 1'b0;
            desc_q   <= 1'b0;
            done_q   <= 1'b0;
            shift_q  <= 2'd0;
            pitch_q  <= '0;
            colour_q <= '0;
            src_q    <= '0;
            dx <= '0; dy <= '0; sx <= '0; sy <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    entry_q  <= entry_now;
                    copy_q   <= cmd_copy;
                    xor_q    <= (rop == ROP_XOR);
                    desc_q   <= desc_now;
                    shift_q  <= depth_shift(depth);
                    pitch_q  <= pitch;
                    colour_q <= colour;
                    dx <= desc_now ? dst_e.x : dst_s.x;
                    dy <= desc_now ? dst_e.y : dst_s.y;
                    sx <= desc_now ? src_e.x : src_s.x;
                    sy <= desc_now ? src_e.y : src_s.y;
                end
                ST_RD_DST: src_q <= mem_rdata;
                ST_WRITE: begin
                    if (last_px) begin
                        done_q <= 1'b1;
                    end else if (dx == row_last_x) begin
                        dx <= row_first_x;
                        sx <= src_first_x;
                        dy <= dy + xstep;
                        sy <= sy + xstep;
                    end else begin
                        dx <= dx + xstep;
                        sx <= sx + xstep;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mem_req = busy;
        mem_we  = (state_q == ST_WRITE);
        addr_pt = (state_q == ST_RD_SRC) ? {sy, sx} : {dy, dx};
        src_val = copy_q ? (xor_q ? src_q : mem_rdata) : colour_q;
        done    = done_q;
    end

    rect_addr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_addr (
        .pt_i(addr_pt), .pitch_i(pitch_q), .shift_i(shift_q), .addr_o(mem_addr)
    );

    rect_rop u_rop (
        .xor_i(xor_q), .src_i(src_val), .dst_i(mem_rdata),
        .shift_i(shift_q), .data_o(mem_wdata)
    );

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !reg_rdata[31] || reg_addr != RIX_CTRL); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr[1:0] & ((2'd1 << shift_q) - 2'd1)) == 2'd0)); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mem_req && !done)); // R9

endmodule

// File: tb/rect_engine_tb.sv
`timescale 1ns/1ps
module rect_engine_tb;

    localparam int PITCH_U = 2;   // 16 pixels per row
    localparam int MEMN    = 4096;
    localparam int SPAN    = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, done;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;

    logic [31:0] mem  [MEMN];
    logic [31:0] refm [MEMN];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rect_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 3'd0;
    endtask

    function automatic int bshift(input int code);
        return (code == 2) ? 2 : ((code == 1 || code == 5) ? 1 : 0);
    endfunction

    function automatic logic [31:0] pmask(input int code);
        int s = bshift(code);
        return (s == 0) ? 32'hFF : ((s == 1) ? 32'hFFFF : 32'hFFFF_FFFF);
    endfunction

    function automatic int paddr(input int x, input int y, input int code);
        return (y * PITCH_U * 8 + x) << bshift(code);
    endfunction

    task automatic set_pts(input logic [2:0] base, input int x, input int y, input int w, input int h);
        wr(base, {16'(y), 16'(x)});
        wr(base + 3'd1, {16'(y + h - 1), 16'(x + w - 1)});
    endtask

    task automatic ref_fill(input int x, input int y, input int w, input int h,
                            input logic [31:0] col, input bit xr, input int code);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) begin
                int a = paddr(x + c, y + r, code);
                refm[a] = (xr ? (col ^ refm[a]) : col) & pmask(code);
            end
    endtask

    task automatic ref_copy(input int sx, input int sy, input int dx, input int dy,
                            input int w, input int h, input bit xr, input int code);
        bit fwd = (sy > dy) || (sy == dy && sx > dx);
        for (int rr = 0; rr < h; rr++)
            for (int cc = 0; cc < w; cc++) begin
                int r = fwd ? rr : h - 1 - rr;
                int c = fwd ? cc : w - 1 - cc;
                int sa = paddr(sx + c, sy + r, code);
                int da = paddr(dx + c, dy + r, code);
                refm[da] = (xr ? (refm[sa] ^ refm[da]) : refm[sa]) & pmask(code);
            end
    endtask

    task automatic cmp_mem(input string tag);
        int bad = -1;
        for (int i = 0; i < SPAN; i++)
            if (bad < 0 && mem[i] !== refm[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, $sformatf("%s mem[%0d]", tag, bad), mem[bad], refm[bad]);
    endtask

    // Launches an operation and checks busy length, done pulse and busy release.
    task automatic run_op(input bit copy, input int exp_cyc, input string tag, input bit poke);
        int cnt = 0;
        bit busy_ok = 1'b1;
        wr(3'd0, {31'd0, copy});
        while (!done && cnt < 5000) begin
            cnt++;
            if (reg_addr == 3'd0 && reg_rdata[31:28] !== 4'hF) busy_ok = 1'b0;
            if (poke && cnt == 5) begin
                reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h000E_000E;
            end else if (poke && cnt == 8) begin
                reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd1;
            end else begin
                reg_we = 1'b0; reg_addr = 3'd0;
            end
            @(negedge clk);
        end
        chk(busy_ok, {tag, " R9 busy high while running"}, !busy_ok, 0);
        chk(cnt == exp_cyc, {tag, " R9 busy cycle count"}, cnt, exp_cyc);
        #1;
        chk(done && reg_rdata[31:28] == 4'h0, {tag, " R10 done with busy clear"},
            reg_rdata[31:28], 0);
        @(negedge clk);
        chk(!done, {tag, " R10 done lasts one cycle"}, done, 0);
    endtask

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < MEMN; i++) begin
            mem[i]  = 32'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
            refm[i] = 32'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(3'd0, v); chk(v == 0, "R12 status after reset", v, 0);
        rd(3'd3, v); chk(v == 0, "R12 format after reset", v, 0);
        chk(!done && !mem_req, "R12 done/mem_req low", {done, mem_req}, 0);

        // R1 readback
        wr(3'd1, 32'h0000_0066); rd(3'd1, v); chk(v == 32'h66, "R1 rop readback", v, 32'h66);
        wr(3'd2, 32'hCAFE_1234); rd(3'd2, v); chk(v == 32'hCAFE_1234, "R1 colour readback", v, 32'hCAFE_1234);
        wr(3'd3, (32'd1 << 16) | PITCH_U); rd(3'd3, v);
        chk(v == ((32'd1 << 16) | PITCH_U), "R1 format readback", v, (32'd1 << 16) | PITCH_U);

        // R4 R2 R3: plain fill at 8 bpp
        wr(3'd1, 32'hCC); wr(3'd2, 32'h1122_33A7); wr(3'd3, (32'd0 << 16) | PITCH_U);
        set_pts(3'd6, 3, 2, 5, 3);
        ref_fill(3, 2, 5, 3, 32'h1122_33A7, 0, 0);
        run_op(0, 15, "R4 fill8", 0); cmp_mem("R4 R2 fill8 contents");

        // R5 R3: XOR fill at 16 bpp
        wr(3'd1, 32'h66); wr(3'd2, 32'h1234_ABCD); wr(3'd3, (32'd1 << 16) | PITCH_U);
        set_pts(3'd6, 0, 4, 16, 2);
        ref_fill(0, 4, 16, 2, 32'h1234_ABCD, 1, 1);
        run_op(0, 64, "R5 xorfill16", 0); cmp_mem("R5 xorfill16 contents");

        // R5 R3: other rop code acts as pass, 15 bpp
        wr(3'd1, 32'h12); wr(3'd2, 32'hFFFF_7C1F); wr(3'd3, (32'd5 << 16) | PITCH_U);
        set_pts(3'd6, 9, 6, 4, 2);
        ref_fill(9, 6, 4, 2, 32'hFFFF_7C1F, 0, 5);
        run_op(0, 8, "R5 rop12 fill15", 0); cmp_mem("R5 R3 fill15 contents");

        // R3: 32 bpp fill
        wr(3'd1, 32'hCC); wr(3'd2, 32'hDEAD_BEEF); wr(3'd3, (32'd2 << 16) | PITCH_U);
        set_pts(3'd6, 10, 14, 6, 2);
        ref_fill(10, 14, 6, 2, 32'hDEAD_BEEF, 0, 2);
        run_op(0, 12, "R3 fill32", 0); cmp_mem("R3 fill32 contents");

        // R6 R7: copies with overlap in all four placements, 8 bpp
        wr(3'd1, 32'hCC); wr(3'd3, (32'd0 << 16) | PITCH_U);
        set_pts(3'd4, 2, 1, 6, 5); set_pts(3'd6, 3, 3, 6, 5);
        ref_copy(2, 1, 3, 3, 6, 5, 0, 0);
        run_op(1, 60, "R7 copy down", 0); cmp_mem("R6 R7 backward copy down");

        wr(3'd3, (32'd1 << 16) | PITCH_U);
        set_pts(3'd4, 4, 6, 5, 6); set_pts(3'd6, 2, 3, 5, 6);
        ref_copy(4, 6, 2, 3, 5, 6, 0, 1);
        run_op(1, 60, "R7 copy up", 0); cmp_mem("R6 R7 forward copy up");

        wr(3'd3, (32'd0 << 16) | PITCH_U);
        set_pts(3'd4, 1, 8, 8, 2); set_pts(3'd6, 3, 8, 8, 2);
        ref_copy(1, 8, 3, 8, 8, 2, 0, 0);
        run_op(1, 32, "R7 copy right", 0); cmp_mem("R7 same-row shift right");

        set_pts(3'd4, 5, 10, 8, 2); set_pts(3'd6, 2, 10, 8, 2);
        ref_copy(5, 10, 2, 10, 8, 2, 0, 0);
        run_op(1, 32, "R7 copy left", 0); cmp_mem("R7 same-row shift left");

        // R8: XOR copy at 32 bpp
        wr(3'd1, 32'h66); wr(3'd3, (32'd2 << 16) | PITCH_U);
        set_pts(3'd4, 0, 12, 6, 3); set_pts(3'd6, 8, 12, 6, 3);
        ref_copy(0, 12, 8, 12, 6, 3, 1, 2);
        run_op(1, 54, "R8 xorcopy32", 0); cmp_mem("R8 xorcopy32 contents");

        // R11 R9: point write and control write while busy are ignored
        wr(3'd1, 32'hCC); wr(3'd2, 32'h0000_0055); wr(3'd3, (32'd0 << 16) | PITCH_U);
        set_pts(3'd6, 1, 0, 10, 6);
        ref_fill(1, 0, 10, 6, 32'h55, 0, 0);
        run_op(0, 60, "R11 poke", 1);
        rd(3'd6, v); chk(v == 32'h0000_0001, "R11 dst start unchanged", v, 32'h1);
        cmp_mem("R11 poke fill contents");
        repeat (3) begin
            @(negedge clk);
            chk(!mem_req, "R9 command while busy ignored", mem_req, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule